// File: doc/BRIEF.md
# Coefficient Boot Loader for Convolver Arrays

This block fills the coefficient and control registers of a chain of image convolver devices straight from a byte-wide non-volatile memory once reset is released. The memory needs no glue logic: the loader drives its address directly and takes the returned byte on the next clock edge. The memory is split into pages, one per device. The loader drives a page number on a separate address field and sweeps the register index inside the page. For each byte it produces a write strobe, a register index, the data byte and a one-hot chip select for the device that owns the page.

The number of devices to fill comes from a configuration input. It is sampled on the first clock after reset and clamped to the supported maximum. The same register sweep runs on every page from page 0 upward. Pages at or above the configured count are never visited. When the last write is done, a done flag rises and the addresses freeze until the next reset. Raising reset at any point aborts the load, and the next release starts again from page 0, index 0.

Top module: `coef_boot_loader`

## Requirements
- R1: While reset is asserted, `reg_wr` is 0, `dev_sel` is all zeros and `done` is 0.
- R2: During a page, `mem_addr` steps 0,1,...,NUM_REGS-1 with one new index per clock, while `page_addr` holds that page's number.
- R3: Each memory address yields exactly one write, one clock later: `reg_wr`=1, `reg_addr` equals the index that was presented, and `reg_data` equals the byte `mem_data` carried during that address cycle.
- R4: `dev_sel` has bit p set (bit 0 = device 0) exactly when a write to page p is on the outputs; it is all zeros otherwise.
- R5: Pages are visited in ascending order from 0. Each page gets the full identical sweep, and the writes run back to back, count x NUM_REGS of them in total.
- R6: `dev_count` is sampled on the first rising edge after reset is released. A value of 0 produces no writes at all, and any value above MAX_DEV (16) is treated as MAX_DEV.
- R7: `done` rises on the clock after the final write. From then on `reg_wr` stays 0 and `mem_addr` and `page_addr` stay stable until reset.
- R8: Changing `dev_count` after it has been sampled has no effect on the number of pages loaded.
- R9: A reset during a load aborts it, and the next release restarts from page 0, index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release starts a load |
| dev_count | input | 5 | Number of devices to fill (0..31, clamped to 16) |
| mem_data | input | 8 | Byte returned by the boot memory for the current address |
| mem_addr | output | 6 | Register index within the page |
| page_addr | output | 4 | Page number, one page per device |
| reg_wr | output | 1 | Register write strobe |
| reg_addr | output | 6 | Register index of the current write |
| reg_data | output | 8 | Data byte of the current write |
| dev_sel | output | 16 | One-hot chip select of the device being written |
| done | output | 1 | All configured pages have been written |

## Verification
Counting rising edges from reset release, fetch k (page k/64, index k%64) is on the address outputs after edge k+1. Its write appears after edge k+2. For a load of K writes, `done` is due after edge K+2. The bench keeps a cycle counter from the release and compares every output at the falling edge against these formulas. The same counter checks the zero-count case, where `done` arrives after edge 2 with no write, and the window after `done`, where the addresses must not move.

// File: rtl/cbl_pkg.sv
package cbl_pkg;

    // Loader sequence phases
    typedef enum logic [1:0] {
        ST_START = 2'd0,  // sample device count
        ST_FETCH = 2'd1,  // present one memory address per clock
        ST_FLUSH = 2'd2,  // last write leaving the pipeline
        ST_DONE  = 2'd3   // halted until reset
    } cbl_state_e;

endpackage

// File: rtl/cbl_seq.sv
module cbl_seq
    import cbl_pkg::*;
#(
    parameter int NUM_REGS = 64,
    parameter int MAX_DEV  = 16,
    localparam int IDX_W  = $clog2(NUM_REGS),
    localparam int PAGE_W = $clog2(MAX_DEV),
    localparam int CNT_W  = $clog2(MAX_DEV + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  dev_count,
    output logic              fetch_vld,
    output logic [IDX_W-1:0]  fetch_idx,
    output logic [PAGE_W-1:0] fetch_page,
    output logic              done
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_REGS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_DEV);

    typedef struct packed {
        cbl_state_e        state;
        logic [PAGE_W-1:0] page;
        logic [IDX_W-1:0]  idx;
        logic [CNT_W-1:0]  count;
    } seq_t;

    seq_t             s_d, s_q;
    logic [CNT_W-1:0] cnt_clamped;
    logic             last_idx;
    logic             last_page;

    always_comb begin
        cnt_clamped = (dev_count > CNT_MAX) ? CNT_MAX : dev_count;
        last_idx    = (s_q.idx == IDX_LAST);
        last_page   = ((CNT_W'(s_q.page) + CNT_W'(1)) == s_q.count);
        s_d         = s_q;
        unique case (s_q.state)
            ST_START: begin
                s_d.count = cnt_clamped;
                s_d.page  = '0;
                s_d.idx   = '0;
                s_d.state = (cnt_clamped == '0) ? ST_FLUSH : ST_FETCH;
            end
            ST_FETCH: begin
                if (last_idx) begin
                    if (last_page) begin
                        s_d.state = ST_FLUSH;   // addresses stay frozen
                    end else begin
                        s_d.page = s_q.page + 1'b1;
                        s_d.idx  = '0;
                    end
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            ST_FLUSH: s_d.state = ST_DONE;
            default:  s_d = s_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_START, page: '0, idx: '0, count: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign fetch_vld  = (s_q.state == ST_FETCH);
    assign fetch_idx  = s_q.idx;
    assign fetch_page = s_q.page;
    assign done       = (s_q.state == ST_DONE);

    // R2: index advances by one per clock inside a page, page held
    assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_FETCH && !last_idx) |=>
        (s_q.state == ST_FETCH && s_q.idx == $past(s_q.idx) + 1'b1 && $stable(s_q.page)));

    // R5: after a non-final page, the next page starts at index 0
    assert_page_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_FETCH && last_idx && !last_page) |=>
        (s_q.state == ST_FETCH && s_q.idx == '0 && s_q.page == $past(s_q.page) + 1'b1));

    // R6: no page at or above the sampled count is ever fetched
    assert_page_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_FETCH) |-> (CNT_W'(s_q.page) < s_q.count));

    // R7: halted state keeps addresses frozen
    assert_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_DONE) |=>
        (s_q.state == ST_DONE && $stable(s_q.page) && $stable(s_q.idx)));

    // R8: sampled count never changes after the start phase
    assert_count_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state != ST_START) |=> $stable(s_q.count));

endmodule

// File: rtl/cbl_wstage.sv
module cbl_wstage #(
    parameter int IDX_W  = 6,
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_vld,
    input  logic [IDX_W-1:0]  fetch_idx,
    input  logic [PAGE_W-1:0] fetch_page,
    input  logic [DATA_W-1:0] mem_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [PAGE_W-1:0] wr_page,
    output logic [DATA_W-1:0] wr_data
);

    typedef struct packed {
        logic              vld;
        logic [IDX_W-1:0]  idx;
        logic [PAGE_W-1:0] page;
        logic [DATA_W-1:0] data;
    } wst_t;

    wst_t w_d, w_q;

    always_comb begin
        w_d     = w_q;
        w_d.vld = fetch_vld;
        if (fetch_vld) begin
            w_d.idx  = fetch_idx;
            w_d.page = fetch_page;
            w_d.data = mem_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign wr_en   = w_q.vld;
    assign wr_idx  = w_q.idx;
    assign wr_page = w_q.page;
    assign wr_data = w_q.data;

    // R3: every fetch turns into one write on the next clock with its index and byte
    assert_write_lag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_vld |=> (wr_en && wr_idx == $past(fetch_idx) &&
                       wr_page == $past(fetch_page) && wr_data == $past(mem_data)));

    // R3: no write without a fetch in the cycle before
    assert_no_stray_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_vld |=> !wr_en);

endmodule

// File: rtl/cbl_csdec.sv
module cbl_csdec #(
    parameter int MAX_DEV = 16,
    parameter int PAGE_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PAGE_W-1:0]  wr_page,
    output logic [MAX_DEV-1:0] dev_sel
);

    for (genvar g = 0; g < MAX_DEV; g++) begin : g_sel
        assign dev_sel[g] = wr_en && (wr_page == PAGE_W'(g));
    end

    // R4: at most one device selected
    assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_sel));

    // R4: no select while idle
    assert_sel_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (dev_sel == '0));

    // R4: a write always selects exactly one device
    assert_sel_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($countones(dev_sel) == 1));

endmodule

// File: rtl/coef_boot_loader.sv
module coef_boot_loader #(
    parameter int NUM_REGS = 64,
    parameter int MAX_DEV  = 16,
    parameter int DATA_W   = 8,
    localparam int IDX_W  = $clog2(NUM_REGS),
    localparam int PAGE_W = $clog2(MAX_DEV),
    localparam int CNT_W  = $clog2(MAX_DEV + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   dev_count,
    input  logic [DATA_W-1:0]  mem_data,
    output logic [IDX_W-1:0]   mem_addr,
    output logic [PAGE_W-1:0]  page_addr,
    output logic               reg_wr,
    output logic [IDX_W-1:0]   reg_addr,
    output logic [DATA_W-1:0]  reg_data,
    output logic [MAX_DEV-1:0] dev_sel,
    output logic               done
);

    logic              fetch_vld;
    logic [IDX_W-1:0]  fetch_idx;
    logic [PAGE_W-1:0] fetch_page;
    logic [PAGE_W-1:0] wr_page;

    cbl_seq #(
        .NUM_REGS (NUM_REGS),
        .MAX_DEV  (MAX_DEV)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_count  (dev_count),
        .fetch_vld  (fetch_vld),
        .fetch_idx  (fetch_idx),
        .fetch_page (fetch_page),
        .done       (done)
    );

    cbl_wstage #(
        .IDX_W  (IDX_W),
        .PAGE_W (PAGE_W),
        .DATA_W (DATA_W)
    ) wstage_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_vld  (fetch_vld),
        .fetch_idx  (fetch_idx),
        .fetch_page (fetch_page),
        .mem_data   (mem_data),
        .wr_en      (reg_wr),
        .wr_idx     (reg_addr),
        .wr_page    (wr_page),
        .wr_data    (reg_data)
    );

    cbl_csdec #(
        .MAX_DEV (MAX_DEV),
        .PAGE_W  (PAGE_W)
    ) csdec_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_page (wr_page),
        .dev_sel (dev_sel)
    );

    assign mem_addr  = fetch_idx;
    assign page_addr = fetch_page;

    // R7: once finished, the loader issues no further writes
    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!reg_wr && dev_sel == '0));

    // R7: done never drops while reset is released
    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

endmodule

// File: tb/coef_boot_loader_tb_top.sv
module coef_boot_loader_tb_top;

    localparam int N   = 64;
    localparam int DEV = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  dev_count = 5'd0;
    logic [7:0]  mem_data;
    logic [5:0]  mem_addr;
    logic [3:0]  page_addr;
    logic        reg_wr;
    logic [5:0]  reg_addr;
    logic [7:0]  reg_data;
    logic [15:0] dev_sel;
    logic        done;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] rom_byte(input int pg, input int ix);
        return 8'(((pg * 29) + (ix * 7) + 11) ^ (pg << 4));
    endfunction

    assign mem_data = rom_byte(int'(page_addr), int'(mem_addr));

    coef_boot_loader dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_count (dev_count),
        .mem_data  (mem_data),
        .mem_addr  (mem_addr),
        .page_addr (page_addr),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_data  (reg_data),
        .dev_sel   (dev_sel),
        .done      (done)
    );

    // stimulus table: requested count, expected pages loaded
    localparam int NVEC = 6;
    localparam int CNT_TAB [NVEC] = '{1, 2, 5, 16, 0, 23};
    localparam int PG_TAB  [NVEC] = '{1, 2, 5, 16, 0, 16};

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic reset_phase(input int cnt);
        @(negedge clk);
        dev_count = 5'(cnt);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(reg_wr == 1'b0, "R1 reg_wr in reset", int'(reg_wr), 0);
        chk(dev_sel == '0,  "R1 dev_sel in reset", int'(dev_sel), 0);
        chk(done == 1'b0,   "R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
    endtask

    // Runs a full load; poke changes dev_count after it has been sampled
    task automatic load_run(input int cnt, input int pages, input bit poke);
        int k_tot;
        int wr_seen;
        logic [5:0] prev_addr;
        logic [3:0] prev_page;
        k_tot = pages * N;
        wr_seen = 0;
        prev_addr = '0;
        prev_page = '0;
        reset_phase(cnt);
        for (int c = 1; c <= k_tot + 6; c++) begin
            @(negedge clk);
            if (poke && c == 3) dev_count = 5'd16;  // R8 late change
            if (c <= k_tot) begin
                chk(int'(mem_addr) == (c - 1) % N, "R2 mem_addr", int'(mem_addr), (c - 1) % N);
                chk(int'(page_addr) == (c - 1) / N, "R5 page_addr", int'(page_addr), (c - 1) / N);
            end
            if (c >= 2 && c <= k_tot + 1) begin
                int k;
                int pg;
                int ix;
                k = c - 2;
                pg = k / N;
                ix = k % N;
                wr_seen++;
                chk(reg_wr == 1'b1, "R3 reg_wr", int'(reg_wr), 1);
                chk(int'(reg_addr) == ix, "R3 reg_addr", int'(reg_addr), ix);
                chk(reg_data == rom_byte(pg, ix), "R3 reg_data", int'(reg_data), int'(rom_byte(pg, ix)));
                chk(dev_sel == 16'(1 << pg), "R4 dev_sel", int'(dev_sel), 1 << pg);
            end else begin
                chk(reg_wr == 1'b0 && dev_sel == '0, "R4 idle select", int'(dev_sel), 0);
            end
            if (c >= k_tot + 2) begin
                chk(done == 1'b1, "R7 done", int'(done), 1);
            end else begin
                chk(done == 1'b0, "R7 done early", int'(done), 0);
            end
            if (c > k_tot + 2) begin
                chk(mem_addr == prev_addr && page_addr == prev_page, "R7 address frozen",
                    int'({page_addr, mem_addr}), int'({prev_page, prev_addr}));
            end
            prev_addr = mem_addr;
            prev_page = page_addr;
        end
        if (pages == 0) chk(wr_seen == 0, "R6 zero count writes", wr_seen, 0);
        else            chk(wr_seen == k_tot, "R5 total writes", wr_seen, k_tot);
    endtask

    initial begin
        // table walk: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            load_run(CNT_TAB[v], PG_TAB[v], 1'b0);
        end
        // R8: late change of dev_count is ignored
        load_run(2, 2, 1'b1);
        // R9: abort mid-load, reset state, then a clean restart from page 0
        reset_phase(3);
        repeat (100) @(negedge clk);
        chk(reg_wr == 1'b1, "R9 load running", int'(reg_wr), 1);
        rst_n = 1'b0;
        #1;
        chk(reg_wr == 1'b0 && dev_sel == '0, "R9 abort clears write", int'(dev_sel), 0);
        chk(mem_addr == '0 && page_addr == '0, "R9 abort clears address",
            int'({page_addr, mem_addr}), 0);
        load_run(1, 1, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule